// File: doc/BRIEF.md
# Two-Context Switch-on-Event Thread Selector

This block picks which of two hardware thread contexts owns a coarse-grained multithreaded in-order pipeline. A context keeps the pipeline until something worth switching for happens. That can be a long-latency miss, a synchronization fault, an explicit yield hint, a request to enter low power, a fairness timeout, or the pipeline sitting idle while the other context has become ready again. On each switch the block raises a one-cycle flush. It flips the active context ID in the cycle after that flush, and it reports which event caused the switch.

Each context has two readiness conditions. One is a miss wait, cleared by that context's data-return strobe. The other is a low-power sleep, cleared by its wake strobe. A context is ready when neither is set. The block never hands the pipeline to a context that is not ready. If a miss leaves both contexts not ready, the pipeline stays on the current context and reports idle. The first context whose data returns is then resumed.

The timeout limit is an input. A value of zero turns the fairness timeout off.

Top module: `soe_thread_sel`

## Requirements
- R1: After reset the active ID is 0, both ready bits are 1, the flush is 0, the cause is 0 and idle is 0.
- R2: When both contexts are ready, a miss by the active context raises the flush in the next cycle with cause 1. In that same cycle the missing context's ready bit reads 0.
- R3: The flush lasts exactly one cycle. The active ID toggles in the cycle after the flush and at no other time. Event inputs seen during the flush cycle have no effect.
- R4: A data return for a context clears its miss wait. The active context switches away on a data return only in one case: the active context is not ready and the peer has just become ready. That resume switch reports cause 6.
- R5: When the peer is not ready, no switch happens. A miss still marks the active context not ready, which raises idle. Events from an idle active context are ignored.
- R6: With a nonzero limit L, a context that has been active since a switch is flushed away L+1 cycles after the cycle in which it became active, with cause 5. The count restarts at every switch. A limit of 0 disables the timeout.
- R7: A timeout is ignored while the peer is not ready. It switches with cause 5 in the cycle after the peer becomes ready.
- R8: A switch hint switches with cause 4 and leaves both ready bits unchanged. It is ignored when the peer is not ready.
- R9: A synchronization fault switches with cause 3 and leaves both ready bits unchanged.
- R10: A low-power request switches with cause 2 and marks the requester not ready. Only that context's wake strobe clears the mark; a data return does not.
- R11: Events arriving in the same cycle produce one flush. The cause follows this priority: miss, low power, sync fault, hint, timeout, resume. A low-power request that loses to a miss is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_i | input | 1 | Active context took a long-latency miss |
| hint_i | input | 1 | Active context decoded a switch hint |
| sync_fault_i | input | 1 | Active context took a synchronization fault |
| sleep_req_i | input | 1 | Active context requests low power |
| data_ret_i | input | 2 | Per-context data-return strobe |
| wake_i | input | 2 | Per-context wake strobe |
| tmo_limit_i | input | CNT_W | Fairness timeout in cycles, 0 disables |
| active_o | output | 1 | Active context ID |
| flush_o | output | 1 | One-cycle pipeline flush |
| cause_o | output | 3 | Cause code of the latest switch |
| ready_o | output | 2 | Per-context ready status |
| idle_o | output | 1 | Active context is not ready |

## Verification
The bench injects a miss while the peer is already waiting. A design that switched anyway would hand the pipeline to a stalled context; one that forgot to mark the miss would never report idle or resume. It also raises a miss during the flush cycle, which a design that did not gate events there would wrongly record. It asserts miss, low power and hint together and then clears the context with a data return alone, which shows whether the losing sleep request leaked into the ready state. Timeout tests measure the exact cycle of the flush twice in a row and hold a timeout against a not-ready peer, catching off-by-one counts, counters that do not restart, and timeouts that switch to a stalled context.

// File: rtl/soe_pkg.sv
`timescale 1ns/1ps
package soe_pkg;

    localparam int NUM_CTX = 2;

    typedef logic tid_t;
    typedef logic [NUM_CTX-1:0] ctx_vec_t;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_MISS   = 3'd1,
        CAUSE_SLEEP  = 3'd2,
        CAUSE_SYNC   = 3'd3,
        CAUSE_HINT   = 3'd4,
        CAUSE_TMO    = 3'd5,
        CAUSE_RESUME = 3'd6
    } cause_e;

    typedef struct packed {
        logic miss;
        logic sleep;
        logic sync;
        logic hint;
        logic tmo;
        logic resume;
    } evt_t;

    function automatic tid_t peer_of(tid_t t);
        return ~t;
    endfunction

    function automatic ctx_vec_t tid_mask(tid_t t);
        return ctx_vec_t'(1) << t;
    endfunction

    // Highest-priority event wins; all others in the same cycle are dropped.
    function automatic cause_e rank_cause(evt_t e);
        if (e.miss)        return CAUSE_MISS;
        else if (e.sleep)  return CAUSE_SLEEP;
        else if (e.sync)   return CAUSE_SYNC;
        else if (e.hint)   return CAUSE_HINT;
        else if (e.tmo)    return CAUSE_TMO;
        else if (e.resume) return CAUSE_RESUME;
        else               return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/soe_ctx_state.sv
`timescale 1ns/1ps
module soe_ctx_state
    import soe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctx_vec_t set_wait,
    input  ctx_vec_t set_sleep,
    input  ctx_vec_t data_ret,
    input  ctx_vec_t wake,
    output ctx_vec_t rdy
);

    for (genvar t = 0; t < NUM_CTX; t++) begin : g_ctx
        logic wait_q;
        logic sleep_q;

        // A new mark wins over a release strobe in the same cycle.
        always_ff @(posedge clk) begin
            if (rst) begin
                wait_q  <= 1'b0;
                sleep_q <= 1'b0;
            end else begin
                wait_q  <= set_wait[t]  | (wait_q  & ~data_ret[t]);
                sleep_q <= set_sleep[t] | (sleep_q & ~wake[t]);
            end
        end

        assign rdy[t] = ~(wait_q | sleep_q);
    end

endmodule

// File: rtl/soe_tmo_ctr.sv
`timescale 1ns/1ps
module soe_tmo_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Counts cycles since the last switch and saturates, so a timeout
    // held off by an unready peer stays pending.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expired = (limit != '0) && (cnt_q >= limit);

endmodule

// File: rtl/soe_event_arb.sv
`timescale 1ns/1ps
module soe_event_arb
    import soe_pkg::*;
(
    input  evt_t   evt,
    input  logic   peer_rdy,
    output logic   fire,
    output cause_e cause,
    output logic   want_wait,
    output logic   want_sleep
);

    assign cause      = rank_cause(evt);
    assign fire       = (cause != CAUSE_NONE) && peer_rdy;
    // Marks apply even when no switch is possible.
    assign want_wait  = evt.miss;
    assign want_sleep = evt.sleep && !evt.miss;

endmodule

// File: rtl/soe_thread_sel.sv
`timescale 1ns/1ps
module soe_thread_sel
    import soe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss_i,
    input  logic             hint_i,
    input  logic             sync_fault_i,
    input  logic             sleep_req_i,
    input  logic [1:0]       data_ret_i,
    input  logic [1:0]       wake_i,
    input  logic [CNT_W-1:0] tmo_limit_i,
    output logic             active_o,
    output logic             flush_o,
    output logic [2:0]       cause_o,
    output logic [1:0]       ready_o,
    output logic             idle_o
);

    tid_t     act_q;
    logic     flush_q;
    cause_e   cause_q;

    ctx_vec_t rdy;
    ctx_vec_t set_wait;
    ctx_vec_t set_sleep;
    logic     act_rdy;
    logic     peer_rdy;
    logic     run;
    logic     expired;
    logic     fire;
    logic     want_wait;
    logic     want_sleep;
    cause_e   arb_cause;
    evt_t     evt;

    assign act_rdy  = rdy[act_q];
    assign peer_rdy = rdy[peer_of(act_q)];
    // The active context issues only when ready and not being flushed.
    assign run      = !flush_q && act_rdy;

    always_comb begin
        evt.miss   = run && miss_i;
        evt.sleep  = run && sleep_req_i;
        evt.sync   = run && sync_fault_i;
        evt.hint   = run && hint_i;
        evt.tmo    = run && expired;
        evt.resume = !flush_q && !act_rdy && peer_rdy;
    end

    soe_event_arb u_arb (
        .evt        (evt),
        .peer_rdy   (peer_rdy),
        .fire       (fire),
        .cause      (arb_cause),
        .want_wait  (want_wait),
        .want_sleep (want_sleep)
    );

    assign set_wait  = want_wait  ? tid_mask(act_q) : '0;
    assign set_sleep = want_sleep ? tid_mask(act_q) : '0;

    soe_ctx_state u_ctx (
        .clk       (clk),
        .rst       (rst),
        .set_wait  (set_wait),
        .set_sleep (set_sleep),
        .data_ret  (data_ret_i),
        .wake      (wake_i),
        .rdy       (rdy)
    );

    soe_tmo_ctr #(
        .CNT_W (CNT_W)
    ) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .clr     (flush_q),
        .limit   (tmo_limit_i),
        .expired (expired)
    );

    // Switch sequence: event cycle -> flush cycle -> new ID.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            flush_q <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (flush_q) begin
            act_q   <= peer_of(act_q);
            flush_q <= 1'b0;
        end else if (fire) begin
            flush_q <= 1'b1;
            cause_q <= arb_cause;
        end
    end

    assign active_o = act_q;
    assign flush_o  = flush_q;
    assign cause_o  = cause_q;
    assign ready_o  = rdy;
    assign idle_o   = !act_rdy;

endmodule

// File: rtl/soe_thread_sel_chk.sv
`timescale 1ns/1ps
module soe_thread_sel_chk (
    input logic       clk,
    input logic       rst,
    input logic       miss_i,
    input logic       active_o,
    input logic       flush_o,
    input logic [2:0] cause_o,
    input logic [1:0] ready_o,
    input logic       idle_o
);

    a_r3_flush_pulse: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> !flush_o);

    a_r3_flip_after_flush: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> (active_o != $past(active_o)));

    a_r3_id_held: assert property (@(posedge clk) disable iff (rst)
        !flush_o |=> $stable(active_o));

    a_r2_miss_marks: assert property (@(posedge clk) disable iff (rst)
        (!flush_o && !idle_o && miss_i) |=> !ready_o[$past(active_o)]);

    a_r5_target_ready: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> ready_o[~active_o]);

    a_r11_cause_set: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> (cause_o != 3'd0));

endmodule

bind soe_thread_sel soe_thread_sel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .miss_i   (miss_i),
    .active_o (active_o),
    .flush_o  (flush_o),
    .cause_o  (cause_o),
    .ready_o  (ready_o),
    .idle_o   (idle_o)
);

// File: tb/sim_soe_thread_sel.sv
`timescale 1ns/1ps
module sim_soe_thread_sel;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             miss_i = 1'b0;
    logic             hint_i = 1'b0;
    logic             sync_fault_i = 1'b0;
    logic             sleep_req_i = 1'b0;
    logic [1:0]       data_ret_i = 2'b00;
    logic [1:0]       wake_i = 2'b00;
    logic [CNT_W-1:0] tmo_limit_i = '0;
    logic             active_o;
    logic             flush_o;
    logic [2:0]       cause_o;
    logic [1:0]       ready_o;
    logic             idle_o;

    int   n_checks = 0;
    int   n_errors = 0;
    logic exp_act  = 1'b0;

    always #2 clk = ~clk;

    soe_thread_sel #(.CNT_W(CNT_W)) u0 (
        .clk          (clk),
        .rst          (rst),
        .miss_i       (miss_i),
        .hint_i       (hint_i),
        .sync_fault_i (sync_fault_i),
        .sleep_req_i  (sleep_req_i),
        .data_ret_i   (data_ret_i),
        .wake_i       (wake_i),
        .tmo_limit_i  (tmo_limit_i),
        .active_o     (active_o),
        .flush_o      (flush_o),
        .cause_o      (cause_o),
        .ready_o      (ready_o),
        .idle_o       (idle_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] msk(logic t);
        return 2'b01 << t;
    endfunction

    task automatic t_reset();
        check("R1 active", 32'(active_o), 0);
        check("R1 ready", 32'(ready_o), 32'h3);
        check("R1 flush", 32'(flush_o), 0);
        check("R1 cause", 32'(cause_o), 0);
        check("R1 idle", 32'(idle_o), 0);
    endtask

    task automatic t_miss();
        miss_i = 1'b1;
        tick();
        miss_i = 1'b0;
        check("R2 flush", 32'(flush_o), 1);
        check("R2 cause", 32'(cause_o), 1);
        check("R2 ready", 32'(ready_o), 32'(2'b11 & ~msk(exp_act)));
        check("R3 id during flush", 32'(active_o), 32'(exp_act));
        tick();
        exp_act = ~exp_act;
        check("R3 flush pulse", 32'(flush_o), 0);
        check("R3 id flip", 32'(active_o), 32'(exp_act));
        data_ret_i = msk(~exp_act);
        tick();
        data_ret_i = 2'b00;
        check("R4 ready back", 32'(ready_o), 32'h3);
        check("R4 no switch", 32'(flush_o), 0);
        tick();
        check("R4 still no switch", 32'(flush_o), 0);
        check("R4 id kept", 32'(active_o), 32'(exp_act));
    endtask

    task automatic t_hint();
        hint_i = 1'b1;
        tick();
        hint_i = 1'b0;
        miss_i = 1'b1;
        check("R8 flush", 32'(flush_o), 1);
        check("R8 cause", 32'(cause_o), 4);
        check("R8 ready", 32'(ready_o), 32'h3);
        tick();
        miss_i = 1'b0;
        exp_act = ~exp_act;
        check("R3 id flip", 32'(active_o), 32'(exp_act));
        check("R3 miss in flush ignored", 32'(ready_o), 32'h3);
        check("R3 no second flush", 32'(flush_o), 0);
    endtask

    task automatic t_sync();
        sync_fault_i = 1'b1;
        tick();
        sync_fault_i = 1'b0;
        check("R9 flush", 32'(flush_o), 1);
        check("R9 cause", 32'(cause_o), 3);
        check("R9 ready", 32'(ready_o), 32'h3);
        tick();
        exp_act = ~exp_act;
        check("R9 id flip", 32'(active_o), 32'(exp_act));
    endtask

    task automatic t_sleep();
        logic who;
        who = exp_act;
        sleep_req_i = 1'b1;
        tick();
        sleep_req_i = 1'b0;
        check("R10 flush", 32'(flush_o), 1);
        check("R10 cause", 32'(cause_o), 2);
        check("R10 ready", 32'(ready_o), 32'(2'b11 & ~msk(who)));
        tick();
        exp_act = ~exp_act;
        check("R10 id flip", 32'(active_o), 32'(exp_act));
        data_ret_i = msk(who);
        tick();
        data_ret_i = 2'b00;
        check("R10 return does not wake", 32'(ready_o), 32'(2'b11 & ~msk(who)));
        wake_i = msk(who);
        tick();
        wake_i = 2'b00;
        check("R10 wake", 32'(ready_o), 32'h3);
    endtask

    task automatic t_combo();
        logic who;
        who = exp_act;
        miss_i = 1'b1;
        sleep_req_i = 1'b1;
        hint_i = 1'b1;
        tick();
        miss_i = 1'b0;
        sleep_req_i = 1'b0;
        hint_i = 1'b0;
        check("R11 flush", 32'(flush_o), 1);
        check("R11 miss wins", 32'(cause_o), 1);
        tick();
        exp_act = ~exp_act;
        check("R11 single flush", 32'(flush_o), 0);
        check("R11 id flip", 32'(active_o), 32'(exp_act));
        data_ret_i = msk(who);
        tick();
        data_ret_i = 2'b00;
        check("R11 sleep dropped", 32'(ready_o), 32'h3);
        hint_i = 1'b1;
        sync_fault_i = 1'b1;
        tick();
        hint_i = 1'b0;
        sync_fault_i = 1'b0;
        check("R11 sync beats hint", 32'(cause_o), 3);
        tick();
        exp_act = ~exp_act;
        check("R11 id flip 2", 32'(active_o), 32'(exp_act));
    endtask

    task automatic t_idle_resume();
        logic first;
        first = exp_act;
        miss_i = 1'b1;
        tick();
        miss_i = 1'b0;
        tick();
        exp_act = ~exp_act;
        miss_i = 1'b1;
        tick();
        miss_i = 1'b0;
        check("R5 no flush", 32'(flush_o), 0);
        check("R5 both waiting", 32'(ready_o), 0);
        check("R5 idle", 32'(idle_o), 1);
        hint_i = 1'b1;
        tick();
        hint_i = 1'b0;
        check("R5 idle hint ignored", 32'(flush_o), 0);
        check("R5 id kept", 32'(active_o), 32'(exp_act));
        data_ret_i = msk(first);
        tick();
        data_ret_i = 2'b00;
        check("R4 peer ready", 32'(ready_o), 32'(msk(first)));
        check("R4 not yet flushing", 32'(flush_o), 0);
        tick();
        check("R4 resume flush", 32'(flush_o), 1);
        check("R4 resume cause", 32'(cause_o), 6);
        tick();
        exp_act = ~exp_act;
        check("R4 resumed id", 32'(active_o), 32'(first));
        check("R4 idle cleared", 32'(idle_o), 0);
        data_ret_i = msk(~first);
        tick();
        data_ret_i = 2'b00;
        check("R4 both ready", 32'(ready_o), 32'h3);
    endtask

    task automatic t_timeout();
        int k;
        tmo_limit_i = 16'd4;
        hint_i = 1'b1;
        tick();
        hint_i = 1'b0;
        check("R11 hint beats timeout", 32'(cause_o), 4);
        tick();
        exp_act = ~exp_act;
        for (int pass = 0; pass < 2; pass++) begin
            k = 0;
            while (flush_o == 1'b0 && k < 50) begin
                tick();
                k++;
            end
            check("R6 timeout cycles", 32'(k), 5);
            check("R6 timeout cause", 32'(cause_o), 5);
            tick();
            exp_act = ~exp_act;
            check("R6 id flip", 32'(active_o), 32'(exp_act));
        end
        tmo_limit_i = '0;
        repeat (10) tick();
        check("R6 disabled", 32'(flush_o), 0);
        check("R6 disabled id", 32'(active_o), 32'(exp_act));
    endtask

    task automatic t_tmo_blocked();
        logic x;
        x = exp_act;
        miss_i = 1'b1;
        tick();
        miss_i = 1'b0;
        tick();
        exp_act = ~exp_act;
        tmo_limit_i = 16'd3;
        for (int i = 0; i < 8; i++) begin
            tick();
            check("R7 blocked timeout", 32'(flush_o), 0);
        end
        hint_i = 1'b1;
        tick();
        hint_i = 1'b0;
        check("R8 hint blocked", 32'(flush_o), 0);
        data_ret_i = msk(x);
        tick();
        data_ret_i = 2'b00;
        check("R7 peer ready", 32'(ready_o), 32'h3);
        check("R7 not yet", 32'(flush_o), 0);
        tick();
        check("R7 pending timeout fires", 32'(flush_o), 1);
        check("R7 cause", 32'(cause_o), 5);
        tmo_limit_i = '0;
        tick();
        exp_act = ~exp_act;
        check("R7 id flip", 32'(active_o), 32'(x));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_miss();
        t_hint();
        t_sync();
        t_sleep();
        t_combo();
        t_idle_resume();
        t_timeout();
        t_tmo_blocked();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule